// File: doc/BRIEF.md
# Addressed Two-Wire Control Receiver

This block receives write-only control traffic from a shared two-wire bus that has one serial clock line and one serial data line. Several receivers may sit on the same wires, and each one answers only to command words that carry its own 4-bit device code. Both bus lines are synchronised into the system clock domain. The bus clock is oversampled to find its edges, and the stream is cut into 11-bit words. Each word is then decoded either as a command (device code plus instruction) or as a data word (a register value, or a new pointer value when one has been requested).

The block keeps an internal address pointer. After each data write, the pointer can step up, step down or stay where it is. The block issues a one-cycle write strobe with address and data to a neighbouring register file, and a one-cycle clear pulse that wipes that register file. Addresses outside the small valid window never reach the strobe.

Top module: `tw_ctl_rx`

## Requirements
- R1: A frame is a start bit of 1, a write-enable bit, a command flag (1 = command, 0 = data) and 8 payload bits LSB first, each taken on a rising bus-clock edge. The resulting `wr_en` or `regs_clr` pulse lasts one cycle and is seen four system-clock cycles after the falling bus-clock edge that follows the last payload bit reaches the pin.
- R2: A frame whose write-enable bit is 0 is ignored entirely. It gives no strobe, and it changes neither the enable, the pointer, the mode nor a pending pointer load.
- R3: After reset all outputs are 0, the receiver is disabled, the pointer is 00h and the mode is hold. Data words that arrive before an enabling command produce no write.
- R4: Device code 5 in payload bits 3..0 of a command enables the receiver, whatever the instruction. Any other code disables it, and data words are then dropped until a command with code 5 arrives.
- R5: The instruction is payload bits 4,5,6,7 read in that order. The pattern 1,0,0,0 (payload 15h) makes the next data word load the pointer with no write. Any command in between cancels that pointer load.
- R6: The pattern 1,1,0,0 (35h) selects increment, 0,0,1,0 (45h) selects decrement and 1,0,1,0 (55h) selects hold. The mode persists until another mode command arrives, and hold is the mode after reset.
- R7: The write strobe carries the pointer value from before the step. In increment or decrement mode the pointer then moves by one with 8-bit wraparound, even when the write itself was dropped.
- R8: Only addresses 00h..04h produce a strobe. A data word aimed at any other address is discarded.
- R9: The patterns 0,0,0,0 (05h) and 1,1,1,1 (F5h) give a one-cycle `regs_clr` pulse. They leave the pointer, the mode and the enable unchanged.
- R10: The patterns 0,1,0,0 (25h), 0,1,1,1 (E5h) and every other unlisted pattern do nothing beyond enabling the receiver.
- R11: Between frames, rising bus-clock edges with data low are ignored, however many there are. The framing counter returns to hunting after the fourteenth clock of a frame, and the first 1 seen after a word starts the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk | input | 1 | Serial bus clock line (asynchronous) |
| bus_dat | input | 1 | Serial bus data line (asynchronous) |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register address for the strobe |
| wr_data | output | 8 | Register value for the strobe |
| regs_clr | output | 1 | One-cycle register-file clear pulse |

## Verification
On a single data word, the write strobe and the pointer step happen in the same cycle. The strobe must show the pre-step address while the pointer has already moved, and at the ends of the window the step continues even though the write is dropped. This is provoked with long increment and decrement bursts that cross 04h and 00h. The next write after each crossing is compared against an independent model of the pointer. Frames are also sent with no gap, so that the start bit of one frame is being sampled while the previous word is still being decoded, and every strobe is matched cycle by cycle against the model's expected cycle.

// File: rtl/tw_ctl_pkg.sv
package tw_ctl_pkg;

  localparam int PAY_W   = 8;
  localparam int CODE_W  = 4;
  localparam int FRAME_W = PAY_W + 3;

  typedef enum logic [1:0] {
    AM_HOLD = 2'd0,
    AM_INC  = 2'd1,
    AM_DEC  = 2'd2
  } amode_t;

  typedef struct packed {
    logic             rw;
    logic             dc;
    logic [PAY_W-1:0] pay;
  } word_t;

  // instruction patterns as {bit4, bit5, bit6, bit7}
  localparam logic [CODE_W-1:0] INS_CLR_A = 4'b0000;
  localparam logic [CODE_W-1:0] INS_CLR_B = 4'b1111;
  localparam logic [CODE_W-1:0] INS_PTRLD = 4'b1000;
  localparam logic [CODE_W-1:0] INS_INC   = 4'b1100;
  localparam logic [CODE_W-1:0] INS_DEC   = 4'b0010;
  localparam logic [CODE_W-1:0] INS_HOLD  = 4'b1010;

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_clk,
  input  logic bus_dat,
  output logic sck_rise,
  output logic sck_fall,
  output logic dat_s
);

  logic [SYNC:0]   ck_sh;
  logic [SYNC-1:0] dt_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_sh <= '0;
      dt_sh <= '0;
    end else begin
      ck_sh <= {ck_sh[SYNC-1:0], bus_clk};
      dt_sh <= {dt_sh[SYNC-2:0], bus_dat};
    end
  end

  assign sck_rise = ck_sh[SYNC-1] & ~ck_sh[SYNC];
  assign sck_fall = ~ck_sh[SYNC-1] & ck_sh[SYNC];
  assign dat_s    = dt_sh[SYNC-1];

endmodule

// File: rtl/tw_framer.sv
module tw_framer
  import tw_ctl_pkg::*;
#(
  parameter int CNT_LIMIT = 14
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  sck_rise,
  input  logic  sck_fall,
  input  logic  dat_s,
  output logic  word_vld,
  output word_t word_q
);

  localparam int PW   = $clog2(CNT_LIMIT);
  localparam int SH_W = FRAME_W - 1;
  localparam logic [PW-1:0] LAST_BIT = PW'(FRAME_W - 1);
  localparam logic [PW-1:0] TRAIL0   = PW'(FRAME_W);
  localparam logic [PW-1:0] WRAP     = PW'(CNT_LIMIT - 1);

  logic [PW-1:0]   pos;
  logic [SH_W-1:0] shreg;
  logic            full;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos      <= '0;
      shreg    <= '0;
      full     <= 1'b0;
      word_vld <= 1'b0;
      word_q   <= '0;
    end else begin
      word_vld <= 1'b0;
      if (sck_rise) begin
        if (pos == '0 || pos >= TRAIL0) begin
          // hunting or trailing clocks: a 1 opens a new frame
          if (dat_s)             pos <= PW'(1);
          else if (pos == WRAP)  pos <= '0;
          else if (pos != '0)    pos <= pos + 1'b1;
        end else begin
          shreg <= {dat_s, shreg[SH_W-1:1]};
          pos   <= pos + 1'b1;
          if (pos == LAST_BIT) full <= 1'b1;
        end
      end else if (sck_fall && full) begin
        full       <= 1'b0;
        word_vld   <= 1'b1;
        word_q.rw  <= shreg[0];
        word_q.dc  <= shreg[1];
        word_q.pay <= shreg[SH_W-1:2];
      end
    end
  end

  // R1
  word_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld);

endmodule

// File: rtl/tw_cmd_decoder.sv
module tw_cmd_decoder
  import tw_ctl_pkg::*;
#(
  parameter int DEV_CODE = 5,
  parameter int ADDR_W   = 8,
  parameter int MAX_ADDR = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  word_t             word_i,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PAY_W-1:0]  wr_data,
  output logic              regs_clr
);

  localparam logic [CODE_W-1:0] DEV   = CODE_W'(DEV_CODE);
  localparam logic [ADDR_W-1:0] MAX_A = ADDR_W'(MAX_ADDR);

  logic              en_q;
  logic              sel_q;
  amode_t            mode_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [CODE_W-1:0] instr;

  assign instr = {word_i.pay[4], word_i.pay[5], word_i.pay[6], word_i.pay[7]};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      sel_q    <= 1'b0;
      mode_q   <= AM_HOLD;
      ptr_q    <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      regs_clr <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      regs_clr <= 1'b0;
      if (word_vld && word_i.rw) begin
        if (word_i.dc) begin
          sel_q <= 1'b0;
          if (word_i.pay[CODE_W-1:0] != DEV) begin
            en_q <= 1'b0;
          end else begin
            en_q <= 1'b1;
            case (instr)
              INS_CLR_A, INS_CLR_B: regs_clr <= 1'b1;
              INS_PTRLD:            sel_q    <= 1'b1;
              INS_INC:              mode_q   <= AM_INC;
              INS_DEC:              mode_q   <= AM_DEC;
              INS_HOLD:             mode_q   <= AM_HOLD;
              default: ;
            endcase
          end
        end else if (en_q) begin
          if (sel_q) begin
            ptr_q <= word_i.pay[ADDR_W-1:0];
            sel_q <= 1'b0;
          end else begin
            if (ptr_q <= MAX_A) begin
              wr_en   <= 1'b1;
              wr_addr <= ptr_q;
              wr_data <= word_i.pay;
            end
            case (mode_q)
              AM_INC:  ptr_q <= ptr_q + 1'b1;
              AM_DEC:  ptr_q <= ptr_q - 1'b1;
              default: ;
            endcase
          end
        end
      end
    end
  end

  // R2
  rw_low_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (word_vld && !word_i.rw) |=> (!wr_en && !regs_clr));

  // R4
  write_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(en_q));

  // R8
  addr_window_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr <= MAX_A));

  // R7
  inc_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode_q == AM_INC) |-> (ptr_q == wr_addr + 1'b1));

  // R7
  dec_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode_q == AM_DEC) |-> (ptr_q == wr_addr - 1'b1));

  // R9
  clr_not_write_chk: assert property (@(posedge clk) disable iff (rst)
    regs_clr |-> !wr_en);

endmodule

// File: rtl/tw_ctl_rx.sv
module tw_ctl_rx
  import tw_ctl_pkg::*;
#(
  parameter int DEV_CODE    = 5,
  parameter int ADDR_W      = 8,
  parameter int MAX_ADDR    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_LIMIT   = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_clk,
  input  logic              bus_dat,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PAY_W-1:0]  wr_data,
  output logic              regs_clr
);

  logic  sck_rise;
  logic  sck_fall;
  logic  dat_s;
  logic  word_vld;
  word_t word_q;

  tw_line_sync #(.SYNC(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .bus_clk  (bus_clk),
    .bus_dat  (bus_dat),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .dat_s    (dat_s)
  );

  tw_framer #(.CNT_LIMIT(CNT_LIMIT)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .dat_s    (dat_s),
    .word_vld (word_vld),
    .word_q   (word_q)
  );

  tw_cmd_decoder #(
    .DEV_CODE (DEV_CODE),
    .ADDR_W   (ADDR_W),
    .MAX_ADDR (MAX_ADDR)
  ) u_dec (
    .clk      (clk),
    .rst      (rst),
    .word_vld (word_vld),
    .word_i   (word_q),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .regs_clr (regs_clr)
  );

endmodule

// File: tb/sim_tw_ctl_rx.sv
`timescale 1ns/1ps
module sim_tw_ctl_rx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_clk = 1'b0;
  logic       bus_dat = 1'b0;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic       regs_clr;

  always #2.5 clk = ~clk;

  tw_ctl_rx u0 (
    .clk      (clk),
    .rst      (rst),
    .bus_clk  (bus_clk),
    .bus_dat  (bus_dat),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .regs_clr (regs_clr)
  );

  typedef struct {
    int         due;
    logic [7:0] a;
    logic [7:0] d;
    string      tag;
  } ev_t;

  ev_t   wq[$];
  ev_t   cq[$];
  int    cyc = 0;
  int    nchk = 0;
  int    nfail = 0;
  int    fall_cyc = 0;
  bit    done = 0;
  string cur_req = "R3";

  // reference state
  int m_en = 0, m_sel = 0, m_mode = 0, m_ptr = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void model(input bit rw, input bit dc, input logic [7:0] p,
                                input int due, input string tag);
    ev_t e;
    logic [3:0] ins;
    if (!rw) return;
    if (dc) begin
      m_sel = 0;
      if (p[3:0] != 4'd5) begin m_en = 0; return; end
      m_en = 1;
      ins = {p[4], p[5], p[6], p[7]};
      case (ins)
        4'b0000, 4'b1111: begin e.due = due; e.a = 0; e.d = 0; e.tag = tag; cq.push_back(e); end
        4'b1000: m_sel = 1;
        4'b1100: m_mode = 1;
        4'b0010: m_mode = 2;
        4'b1010: m_mode = 0;
        default: ;
      endcase
    end else if (m_en != 0) begin
      if (m_sel != 0) begin
        m_ptr = int'(p); m_sel = 0;
      end else begin
        if (m_ptr <= 4) begin
          e.due = due; e.a = 8'(m_ptr); e.d = p; e.tag = tag; wq.push_back(e);
        end
        if (m_mode == 1) m_ptr = (m_ptr + 1) % 256;
        if (m_mode == 2) m_ptr = (m_ptr + 255) % 256;
      end
    end
  endfunction

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit ew, ec;
      ew = (wq.size() > 0) && (wq[0].due == cyc);
      ec = (cq.size() > 0) && (cq[0].due == cyc);
      if (ew || wr_en) begin
        nchk++;
        if (ew) begin
          if (wr_en !== 1'b1 || wr_addr !== wq[0].a || wr_data !== wq[0].d) begin
            nfail++;
            $display("FAIL %s write: got en=%0b a=%02h d=%02h expected en=1 a=%02h d=%02h",
                     wq[0].tag, wr_en, wr_addr, wr_data, wq[0].a, wq[0].d);
          end
          void'(wq.pop_front());
        end else begin
          nfail++;
          $display("FAIL %s stray write: got en=1 a=%02h d=%02h expected en=0",
                   cur_req, wr_addr, wr_data);
        end
      end
      if (ec || regs_clr) begin
        nchk++;
        if (ec) begin
          if (regs_clr !== 1'b1) begin
            nfail++;
            $display("FAIL %s clear: got %0b expected 1", cq[0].tag, regs_clr);
          end
          void'(cq.pop_front());
        end else begin
          nfail++;
          $display("FAIL %s stray clear: got 1 expected 0", cur_req);
        end
      end
    end
  end

  task automatic bus_bit(input logic b);
    @(negedge clk) bus_dat = b;
    repeat (2) @(negedge clk);
    bus_clk = 1'b1;
    repeat (4) @(negedge clk);
    bus_clk = 1'b0;
    fall_cyc = cyc;
  endtask

  task automatic send(input bit rw, input bit dc, input logic [7:0] p);
    bus_bit(1'b1);
    bus_bit(rw);
    bus_bit(dc);
    for (int i = 0; i < 8; i++) bus_bit(p[i]);
    model(rw, dc, p, fall_cyc + 4, cur_req);
    repeat (2) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] p);  send(1'b1, 1'b1, p); endtask
  task automatic dat(input logic [7:0] p);  send(1'b1, 1'b0, p); endtask

  task automatic idle_clocks(input int n);
    for (int i = 0; i < n; i++) bus_bit(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R3: reset values at the ports
    nchk++;
    if (wr_en !== 1'b0 || regs_clr !== 1'b0 || wr_addr !== 8'h00 || wr_data !== 8'h00) begin
      nfail++;
      $display("FAIL R3 reset: got en=%0b clr=%0b a=%02h d=%02h expected 0 0 00 00",
               wr_en, regs_clr, wr_addr, wr_data);
    end

    cur_req = "R3"; dat(8'hAA); dat(8'h5C);              // disabled: dropped
    cur_req = "R4"; cmd(8'h26); dat(8'h13);              // foreign code: still off
    cur_req = "R1 R4"; cmd(8'h25); dat(8'h11);           // enable, hold at 00
    cur_req = "R6"; dat(8'h22);                          // hold keeps 00
    cur_req = "R4"; cmd(8'h2A); dat(8'h99); cmd(8'h25);  // disable then re-enable
    cur_req = "R5"; cmd(8'h15); dat(8'h03); dat(8'h33);  // load 03, write 03
    cur_req = "R6 R8"; cmd(8'h35); cmd(8'h15); dat(8'h02);
    dat(8'hA0); dat(8'hA1); dat(8'hA2); dat(8'hA3); dat(8'hA4);
    cur_req = "R7"; cmd(8'h45); cmd(8'h15); dat(8'h01);
    dat(8'hB0); dat(8'hB1); dat(8'hB2); dat(8'hB3);      // 01,00, then FF/FE dropped
    cur_req = "R6"; cmd(8'h55); cmd(8'h15); dat(8'h02); dat(8'hC0); dat(8'hC1);
    cur_req = "R5"; cmd(8'h15); cmd(8'h25); dat(8'h5A);  // load cancelled
    cmd(8'h15); cmd(8'h16); cmd(8'h25); dat(8'h5B);      // cancelled by foreign code
    cur_req = "R2"; send(1'b0, 1'b1, 8'h06); send(1'b0, 1'b1, 8'h15);
    send(1'b0, 1'b0, 8'h44); dat(8'h77);                 // still enabled, no load
    cmd(8'h15); send(1'b0, 1'b0, 8'h01); dat(8'h04); dat(8'h78);
    cur_req = "R9"; cmd(8'h05); cmd(8'hF5); dat(8'h66);
    cur_req = "R10"; cmd(8'hE5); cmd(8'h65); cmd(8'h25); dat(8'h67);
    cur_req = "R8"; cmd(8'h35); cmd(8'h15); dat(8'h80); dat(8'hD0);
    cmd(8'h15); dat(8'h04); dat(8'hD1); dat(8'hD2); dat(8'hD3);
    cur_req = "R11"; cmd(8'h55); cmd(8'h15); dat(8'h01);
    idle_clocks(3); dat(8'hE1);
    idle_clocks(20); dat(8'hE2);
    idle_clocks(14); cmd(8'h35); idle_clocks(1); dat(8'hE3); dat(8'hE4);

    repeat (20) @(negedge clk);
    nchk++;
    if (wq.size() != 0 || cq.size() != 0) begin
      nfail++;
      $display("FAIL R1 pending events: got %0d expected 0", wq.size() + cq.size());
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule